// File: doc/BRIEF.md
# Two-Read One-Write Register Array

This block is the general-purpose register storage of a single-cycle processor core. It holds a parameterised number of word-wide entries. Two read ports return entry contents combinationally, each from its own index. One write port stores a word at a chosen index when its enable is high. Entry zero is a constant: it always reads as zero and cannot be changed.

Writes commit on the falling clock edge. Within one cycle, the first half can carry the decoded write request, and the second half can read the stored result through the combinational read ports. The core therefore needs no forwarding path between its write-back and its operand fetch. A parameter selects whether a low level on the synchronous reset clears every entry at the falling edge.

Top module: `dual_read_regfile`

## Requirements
- R1: With default parameters the array holds 32 entries of 32 bits, and each nonzero entry keeps its own value independently of writes to other entries.
- R2: Index 0 returns 0 on both read ports at all times, and a write addressed to index 0 is discarded.
- R3: With wrEn=1 and a nonzero wrIdx, wrData is stored at the falling clock edge. A read of that index returns the old value before that edge and the new value after it, within the same clock cycle.
- R4: With wrEn=0 no entry changes at a falling edge, whatever wrIdx and wrData hold.
- R5: The read ports are combinational and independent. rdDataA follows rdIdxA and rdDataB follows rdIdxB, with no clock edge between an index change and the data.
- R6: When rdIdxA equals rdIdxB, both read ports return the same value.
- R7: With CLEAR_ON_RESET=1, rstN=0 at a falling edge clears every entry to 0, and this clear takes precedence over a write presented at the same edge.
- R8: The index width is derived as clog2(NUM_REGS). With NUM_REGS=64, all three indices are 6 bits wide, and entries up to 63 are writable and readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset clear act on its falling edge |
| rstN | input | 1 | Synchronous active-low reset, sampled at the falling edge |
| wrEn | input | 1 | Write enable |
| wrIdx | input | IDX_W | Index of the entry to write |
| wrData | input | DATA_W | Word to store |
| rdIdxA | input | IDX_W | Index for read port A |
| rdDataA | output | DATA_W | Contents of entry rdIdxA |
| rdIdxB | input | IDX_W | Index for read port B |
| rdDataB | output | DATA_W | Contents of entry rdIdxB |

## Verification
A write and a read of the same entry can fall in one clock cycle. This is the case the falling-edge commit exists for. The bench presents the write and the read index together just after a rising edge. It samples the read port before the falling edge and expects the old contents, then samples again after the falling edge and expects the new word. The reset clear and a write are also made to coincide at one falling edge, and the entry is then judged to read zero.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Strobes issued by the write control to the storage datapath.
  typedef struct packed {
    logic commit;    // store wrData at wrIdx on this falling edge
    logic clearAll;  // zero every entry on this falling edge
  } wrStrobes_t;

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int IDX_W          = 5,
  parameter bit CLEAR_ON_RESET = 1'b1
) (
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output wrStrobes_t       strb
);

  logic idxIsZero;

  assign idxIsZero = (wrIdx == '0);

  always_comb begin
    strb.clearAll = CLEAR_ON_RESET && !rstN;
    // A clear wins over a write; entry zero is never written.
    strb.commit   = wrEn && !idxIsZero && !strb.clearAll;
  end

endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB
);

  logic [NUM_REGS-1:0][DATA_W-1:0] storage;

  // Entry zero is a constant.
  assign storage[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : gEntry
    logic [DATA_W-1:0] q;
    logic              hit;

    assign hit = strb.commit && (wrIdx == IDX_W'(g));

    always_ff @(negedge clk) begin
      if (strb.clearAll) begin
        q <= '0;
      end else if (hit) begin
        q <= wrData;
      end
    end

    assign storage[g] = q;
  end

  function automatic logic [DATA_W-1:0] readEntry(input logic [IDX_W-1:0] idx);
    if (int'(idx) < NUM_REGS) begin
      return storage[idx];
    end
    return '0;
  endfunction

  assign rdDataA = readEntry(rdIdxA);
  assign rdDataB = readEntry(rdIdxB);

  // R2: index zero always reads zero on both ports
  a_r2_zero_port_a : assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == '0) |-> (rdDataA == '0));
  a_r2_zero_port_b : assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB == '0) |-> (rdDataB == '0));

  // R6: identical indices give identical data
  a_r6_same_index : assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == rdIdxB) |-> (rdDataA == rdDataB));

  // R3: a committed write is held in the addressed entry after the falling edge
  a_r3_commit_lands : assert property (@(negedge clk) disable iff (!rstN)
    strb.commit |=> (storage[$past(wrIdx)] == $past(wrData)));

endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile
  import regfile_pkg::*;
#(
  parameter int NUM_REGS       = 32,
  parameter int DATA_W         = 32,
  parameter bit CLEAR_ON_RESET = 1'b1,
  localparam int IDX_W         = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB
);

  wrStrobes_t strb;

  regfile_ctrl #(
    .IDX_W          (IDX_W),
    .CLEAR_ON_RESET (CLEAR_ON_RESET)
  ) i_ctrl (
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .strb  (strb)
  );

  regfile_datapath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .rdIdxA  (rdIdxA),
    .rdDataA (rdDataA),
    .rdIdxB  (rdIdxB),
    .rdDataB (rdDataB)
  );

endmodule

// File: tb/test_dual_read_regfile.sv
module test_dual_read_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdIdxA = '0;
  logic [4:0]  rdIdxB = '0;
  logic [31:0] rdDataA;
  logic [31:0] rdDataB;

  // 64-entry variant for R8
  logic        wWrEn = 1'b0;
  logic [5:0]  wWrIdx = '0;
  logic [31:0] wWrData = '0;
  logic [5:0]  wRdIdxA = '0;
  logic [5:0]  wRdIdxB = '0;
  logic [31:0] wRdDataA;
  logic [31:0] wRdDataB;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_read_regfile i_dual_read_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB)
  );

  dual_read_regfile #(.NUM_REGS(64)) i_wide (
    .clk(clk), .rstN(rstN), .wrEn(wWrEn), .wrIdx(wWrIdx), .wrData(wWrData),
    .rdIdxA(wRdIdxA), .rdDataA(wRdDataA), .rdIdxB(wRdIdxB), .rdDataB(wRdDataB)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  wi;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd1,  32'hA5A5_0001, 5'd1,  5'd0,  32'hA5A5_0001, 32'h0},          // R1 R2
    '{1'b1, 5'd31, 32'hFFFF_FFFF, 5'd31, 5'd1,  32'hFFFF_FFFF, 32'hA5A5_0001},  // R1 R5
    '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0,         32'h0},          // R2
    '{1'b0, 5'd1,  32'h0000_1234, 5'd1,  5'd31, 32'hA5A5_0001, 32'hFFFF_FFFF},  // R4
    '{1'b1, 5'd1,  32'h0000_0042, 5'd1,  5'd1,  32'h0000_0042, 32'h0000_0042},  // R3 R6
    '{1'b1, 5'd16, 32'h8000_0000, 5'd16, 5'd15, 32'h8000_0000, 32'h0},          // R1
    '{1'b1, 5'd15, 32'h0F0F_0F0F, 5'd15, 5'd16, 32'h0F0F_0F0F, 32'h8000_0000},  // R1 R5
    '{1'b0, 5'd0,  32'h0,         5'd31, 5'd0,  32'hFFFF_FFFF, 32'h0}           // R4 R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // Reset: two falling edges with rstN low
    @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1 rstN = 1'b1;
    rdIdxA = 5'd1; rdIdxB = 5'd31;
    #2;
    check("R7 reset clears entry 1", rdDataA, 32'h0);
    check("R7 reset clears entry 31", rdDataB, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      wrEn = VECS[i].we; wrIdx = VECS[i].wi; wrData = VECS[i].wd;
      rdIdxA = VECS[i].ra; rdIdxB = VECS[i].rb;
      @(negedge clk); #2;
      check($sformatf("R1-table vec %0d port A", i), rdDataA, VECS[i].ea);
      check($sformatf("R5 vec %0d port B", i), rdDataB, VECS[i].eb);
    end

    // R3: write and read of entry 16 in one cycle
    @(posedge clk); #1;
    wrEn = 1'b1; wrIdx = 5'd16; wrData = 32'h1357_9BDF; rdIdxA = 5'd16; rdIdxB = 5'd16;
    #2;
    check("R3 old value before falling edge", rdDataA, 32'h8000_0000);
    @(negedge clk); #2;
    check("R3 new value after falling edge", rdDataA, 32'h1357_9BDF);
    check("R6 both ports agree", rdDataB, rdDataA);

    // R5: index change seen without a clock edge
    wrEn = 1'b0;
    rdIdxA = 5'd15; #1;
    check("R5 combinational port A", rdDataA, 32'h0F0F_0F0F);
    rdIdxB = 5'd1; #1;
    check("R5 combinational port B", rdDataB, 32'h0000_0042);

    // R8: 64-entry variant
    @(posedge clk); #1;
    wWrEn = 1'b1; wWrIdx = 6'd63; wWrData = 32'hCAFE_0063;
    @(negedge clk); #2;
    @(posedge clk); #1;
    wWrIdx = 6'd32; wWrData = 32'hCAFE_0032;
    @(negedge clk); #2;
    wWrEn = 1'b0; wRdIdxA = 6'd63; wRdIdxB = 6'd32; #1;
    check("R8 wide entry 63", wRdDataA, 32'hCAFE_0063);
    check("R8 wide entry 32", wRdDataB, 32'hCAFE_0032);

    // R7: reset clear wins over a coincident write
    @(posedge clk); #1;
    rstN = 1'b0; wrEn = 1'b1; wrIdx = 5'd5; wrData = 32'h5555_5555;
    @(negedge clk); #2;
    @(posedge clk); #1;
    rstN = 1'b1; wrEn = 1'b0; rdIdxA = 5'd5; rdIdxB = 5'd31; #1;
    check("R7 clear beats write", rdDataA, 32'h0);
    check("R7 clear entry 31", rdDataB, 32'h0);
    wRdIdxA = 6'd63; #1;
    check("R7 wide clear entry 63", wRdDataA, 32'h0);

    finishRun();
  end

endmodule